// File: doc/BRIEF.md
# LCD Common-Line Row Scanner

This block drives the display side of a bit-mapped LCD refresh. For each common (row) line it produces the frame-RAM row address to read. It takes the wide row that the RAM returns, applies the display polarity and holds the result in a latch for the segment drivers. The host loads a scroll offset, the start line, which names the RAM row shown on common line 0. Changing that offset scrolls the picture vertically without moving any RAM contents.

A line counter restarts at zero on every transition of the frame-polarity input. It then advances by one on each common-period tick and stops at the last common line. The common index is the counter value, or its mirror when the static reverse-scan input is set. The RAM row is the start line plus that index, wrapped at the RAM row count. A start-line write only takes effect at the next frame boundary, so a frame in progress is never torn. The RAM is read asynchronously by the address it is given. The segment latch loads only in the cycle after a new line begins, so host traffic on the RAM port cannot reach the panel between lines.

Top module: `lcd_row_scan`

## Requirements
- R1: In the cycle after synchronous reset, row_addr, com_idx, line_strobe and seg_data are all zero. The pending and active start lines are zero, and the remembered frame polarity is 0.
- R2: A start_we pulse stores start_data as the pending start line. The rows produced are unchanged until the next frame-polarity change adopts it. A write in the same cycle as that change is kept for the following frame.
- R3: When frame_pol differs from its value at the previous clock edge, the line count returns to 0. On the next cycle line_strobe is 1 for that line and the outputs show line 0 under the newly adopted start line.
- R4: A com_tick with no frame change advances the count by one. The new row_addr and com_idx appear one cycle later, with line_strobe high for that cycle. A frame change in the same cycle as a tick wins, so the count goes to 0.
- R5: The count stops at NUM_COMS-1. Further ticks produce no line_strobe and leave row_addr and com_idx unchanged until the next frame change.
- R6: com_idx equals the count when scan_rev is 0 and NUM_COMS-1 minus the count when scan_rev is 1.
- R7: row_addr equals (active start line + com_idx) modulo RAM_ROWS. The 8-bit start line may exceed RAM_ROWS.
- R8: In the cycle after line_strobe, seg_data equals ram_rdata as sampled during the strobe cycle. When inverse was 1 at that edge, every bit is complemented instead.
- R9: In any cycle without line_strobe, changes on ram_rdata or inverse leave seg_data unchanged at the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_we | input | 1 | Host strobe that loads the pending start line |
| start_data | input | START_W | Start line value written by the host |
| frame_pol | input | 1 | Frame polarity; each transition starts a frame |
| com_tick | input | 1 | One pulse per common period |
| scan_rev | input | 1 | Static option: 1 scans common lines in reverse order |
| inverse | input | 1 | Display polarity: 1 complements the latched row |
| row_addr | output | ADDR_W | RAM row to read for the current common line |
| com_idx | output | CNT_W | Common line currently driven |
| line_strobe | output | 1 | High for one cycle when a new line's address appears |
| ram_rdata | input | ROW_W | Row data returned by the RAM for row_addr |
| seg_data | output | ROW_W | Polarity-adjusted row held for the segment drivers |

## Verification
The bench builds the block with its default geometry: 132-bit rows, 120 RAM rows and 88 common lines. With those sizes, start lines between RAM_ROWS and 255 exercise the modulo wrap on the very first line of a frame. Running a full 88-tick frame reaches the hold at the last line and checks the ticks past it. Both scan directions are covered by resetting between phases. The inverse mode and a disturbance of the RAM data between lines are applied against the same geometry.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  // Static common scan direction.
  typedef enum logic {
    SCAN_FWD = 1'b0,
    SCAN_REV = 1'b1
  } scan_dir_e;

  // Display polarity applied at the segment latch.
  typedef enum logic {
    POL_NORMAL  = 1'b0,
    POL_INVERSE = 1'b1
  } pol_mode_e;

  // Width helper: larger of two widths.
  function automatic int unsigned max_w(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lcd_start_line.sv
module lcd_start_line #(
  parameter int unsigned START_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [START_W-1:0] wr_val,
  input  logic               frame_edge,
  output logic [START_W-1:0] start_next
);

  logic [START_W-1:0] pending_q;
  logic [START_W-1:0] active_q;

  // Value in force for the line that begins at this edge.
  always_comb begin
    start_next = frame_edge ? pending_q : active_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= '0;
      active_q  <= '0;
    end else begin
      if (frame_edge) active_q <= pending_q;
      if (wr_en)      pending_q <= wr_val;
    end
  end

endmodule

// File: rtl/lcd_line_counter.sv
module lcd_line_counter #(
  parameter int unsigned NUM_COMS = 88,
  localparam int unsigned CNT_W = (NUM_COMS > 1) ? $clog2(NUM_COMS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_pol,
  input  logic             com_tick,
  output logic             frame_edge,
  output logic             step,
  output logic [CNT_W-1:0] cnt_next
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_COMS - 1);

  logic             pol_q;
  logic [CNT_W-1:0] cnt_q;
  logic             can_adv;

  always_comb begin
    frame_edge = (frame_pol != pol_q);
    can_adv    = com_tick && (cnt_q != LAST);
    step       = frame_edge || can_adv;
    if (frame_edge)   cnt_next = '0;
    else if (can_adv) cnt_next = cnt_q + CNT_W'(1);
    else              cnt_next = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      pol_q <= frame_pol;
      cnt_q <= cnt_next;
    end
  end

endmodule

// File: rtl/lcd_row_map.sv
module lcd_row_map
  import lcd_scan_pkg::*;
#(
  parameter int unsigned NUM_COMS = 88,
  parameter int unsigned RAM_ROWS = 120,
  parameter int unsigned START_W  = 8,
  localparam int unsigned CNT_W  = (NUM_COMS > 1) ? $clog2(NUM_COMS) : 1,
  localparam int unsigned ADDR_W = (RAM_ROWS > 1) ? $clog2(RAM_ROWS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step,
  input  logic [CNT_W-1:0]   cnt_next,
  input  logic [START_W-1:0] start_next,
  input  scan_dir_e          dir,
  output logic [ADDR_W-1:0]  row_addr,
  output logic [CNT_W-1:0]   com_idx,
  output logic               line_strobe
);

  localparam int unsigned SUM_W = max_w(START_W, CNT_W) + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_COMS - 1);

  logic [CNT_W-1:0]  idx_d;
  logic [SUM_W-1:0]  sum_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    idx_d  = (dir == SCAN_REV) ? (LAST - cnt_next) : cnt_next;
    sum_d  = SUM_W'(start_next) + SUM_W'(idx_d);
    addr_d = ADDR_W'(sum_d % SUM_W'(RAM_ROWS));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_addr    <= '0;
      com_idx     <= '0;
      line_strobe <= 1'b0;
    end else begin
      line_strobe <= step;
      if (step) begin
        row_addr <= addr_d;
        com_idx  <= idx_d;
      end
    end
  end

endmodule

// File: rtl/lcd_row_latch.sv
module lcd_row_latch
  import lcd_scan_pkg::*;
#(
  parameter int unsigned ROW_W = 132
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  pol_mode_e        pol,
  input  logic [ROW_W-1:0] rdata,
  output logic [ROW_W-1:0] seg_q
);

  logic [ROW_W-1:0] pol_mask;

  // Replicate the polarity bit across the row.
  generate
    for (genvar b = 0; b < ROW_W; b++) begin : g_mask
      assign pol_mask[b] = (pol == POL_INVERSE);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       seg_q <= '0;
    else if (load) seg_q <= rdata ^ pol_mask;
  end

endmodule

// File: rtl/lcd_row_scan.sv
module lcd_row_scan
  import lcd_scan_pkg::*;
#(
  parameter int unsigned ROW_W    = 132,
  parameter int unsigned RAM_ROWS = 120,
  parameter int unsigned NUM_COMS = 88,
  parameter int unsigned START_W  = 8,
  localparam int unsigned CNT_W  = (NUM_COMS > 1) ? $clog2(NUM_COMS) : 1,
  localparam int unsigned ADDR_W = (RAM_ROWS > 1) ? $clog2(RAM_ROWS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_we,
  input  logic [START_W-1:0] start_data,
  input  logic               frame_pol,
  input  logic               com_tick,
  input  logic               scan_rev,
  input  logic               inverse,
  output logic [ADDR_W-1:0]  row_addr,
  output logic [CNT_W-1:0]   com_idx,
  output logic               line_strobe,
  input  logic [ROW_W-1:0]   ram_rdata,
  output logic [ROW_W-1:0]   seg_data
);

  logic               frame_edge;
  logic               step;
  logic [CNT_W-1:0]   cnt_next;
  logic [START_W-1:0] start_next;
  scan_dir_e          dir;
  pol_mode_e          pol;

  assign dir = scan_dir_e'(scan_rev);
  assign pol = pol_mode_e'(inverse);

  lcd_line_counter #(.NUM_COMS(NUM_COMS)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .frame_pol  (frame_pol),
    .com_tick   (com_tick),
    .frame_edge (frame_edge),
    .step       (step),
    .cnt_next   (cnt_next)
  );

  lcd_start_line #(.START_W(START_W)) u_start (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (start_we),
    .wr_val     (start_data),
    .frame_edge (frame_edge),
    .start_next (start_next)
  );

  lcd_row_map #(
    .NUM_COMS (NUM_COMS),
    .RAM_ROWS (RAM_ROWS),
    .START_W  (START_W)
  ) u_map (
    .clk         (clk),
    .rst         (rst),
    .step        (step),
    .cnt_next    (cnt_next),
    .start_next  (start_next),
    .dir         (dir),
    .row_addr    (row_addr),
    .com_idx     (com_idx),
    .line_strobe (line_strobe)
  );

  lcd_row_latch #(.ROW_W(ROW_W)) u_latch (
    .clk   (clk),
    .rst   (rst),
    .load  (line_strobe),
    .pol   (pol),
    .rdata (ram_rdata),
    .seg_q (seg_data)
  );

endmodule

// File: rtl/lcd_row_scan_chk.sv
module lcd_row_scan_chk #(
  parameter int unsigned ROW_W    = 132,
  parameter int unsigned RAM_ROWS = 120,
  parameter int unsigned NUM_COMS = 88,
  parameter int unsigned CNT_W    = 7,
  parameter int unsigned ADDR_W   = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_pol,
  input logic              inverse,
  input logic [ADDR_W-1:0] row_addr,
  input logic [CNT_W-1:0]  com_idx,
  input logic              line_strobe,
  input logic [ROW_W-1:0]  ram_rdata,
  input logic [ROW_W-1:0]  seg_data
);

  // R3: a polarity change is followed by a new line
  assert_frame_restart_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && (frame_pol != $past(frame_pol))) |=> line_strobe);

  // R4 / R5: address moves only together with the strobe
  assert_addr_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !line_strobe |-> ($stable(row_addr) && $stable(com_idx)));

  // R7: row address stays inside the RAM
  assert_addr_range_R7: assert property (@(posedge clk) disable iff (rst)
    (row_addr < ADDR_W'(RAM_ROWS)) && (com_idx < CNT_W'(NUM_COMS)));

  // R8: latch captures the strobed row with polarity
  assert_latch_load_R8: assert property (@(posedge clk) disable iff (rst)
    line_strobe |=> (seg_data == ($past(inverse) ? ~$past(ram_rdata) : $past(ram_rdata))));

  // R9: no strobe, no change on the segment latch
  assert_latch_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !line_strobe |=> $stable(seg_data));

endmodule

bind lcd_row_scan lcd_row_scan_chk #(
  .ROW_W    (ROW_W),
  .RAM_ROWS (RAM_ROWS),
  .NUM_COMS (NUM_COMS),
  .CNT_W    (CNT_W),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .frame_pol   (frame_pol),
  .inverse     (inverse),
  .row_addr    (row_addr),
  .com_idx     (com_idx),
  .line_strobe (line_strobe),
  .ram_rdata   (ram_rdata),
  .seg_data    (seg_data)
);

// File: tb/tb_lcd_row_scan.sv
module tb_lcd_row_scan;

  localparam int ROW_W = 132;
  localparam int ROWS  = 120;
  localparam int COMS  = 88;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_we = 1'b0;
  logic [7:0]       start_data = '0;
  logic             frame_pol = 1'b0;
  logic             com_tick = 1'b0;
  logic             scan_rev = 1'b0;
  logic             inverse = 1'b0;
  logic             perturb = 1'b0;
  logic [6:0]       row_addr;
  logic [6:0]       com_idx;
  logic             line_strobe;
  logic [ROW_W-1:0] ram_rdata;
  logic [ROW_W-1:0] seg_data;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  lcd_row_scan dut (
    .clk(clk), .rst(rst), .start_we(start_we), .start_data(start_data),
    .frame_pol(frame_pol), .com_tick(com_tick), .scan_rev(scan_rev),
    .inverse(inverse), .row_addr(row_addr), .com_idx(com_idx),
    .line_strobe(line_strobe), .ram_rdata(ram_rdata), .seg_data(seg_data)
  );

  // RAM model: contents are a function of the row number.
  function automatic logic [ROW_W-1:0] pat(input int r);
    logic [ROW_W-1:0] v;
    for (int i = 0; i < ROW_W; i++) v[i] = (((r * 5 + i * 3) % 7) < 3);
    return v;
  endfunction

  localparam logic [ROW_W-1:0] DISTURB = {33{4'b1001}};

  assign ram_rdata = pat(int'(row_addr)) ^ (perturb ? DISTURB : '0);

  // Behavioural reference, advanced on every clock.
  int               m_pol, m_cnt, m_pend, m_act, m_row, m_com;
  bit               m_strobe;
  logic [ROW_W-1:0] m_seg;

  always @(posedge clk) begin
    logic [ROW_W-1:0] nseg;
    if (rst) begin
      m_pol = 0; m_cnt = 0; m_pend = 0; m_act = 0;
      m_row = 0; m_com = 0; m_strobe = 0; m_seg = '0;
    end else begin
      nseg = m_seg;
      if (m_strobe) begin
        nseg = pat(m_row) ^ (perturb ? DISTURB : '0);
        if (inverse) nseg = ~nseg;
      end
      m_strobe = 0;
      if (int'(frame_pol) != m_pol) begin
        m_act = m_pend; m_cnt = 0; m_strobe = 1;
      end else if (com_tick && m_cnt < COMS - 1) begin
        m_cnt++; m_strobe = 1;
      end
      m_pol = int'(frame_pol);
      if (start_we) m_pend = int'(start_data);
      if (m_strobe) begin
        m_com = scan_rev ? (COMS - 1 - m_cnt) : m_cnt;
        m_row = (m_act + m_com) % ROWS;
      end
      m_seg = nseg;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Per-clock comparison against the model.
  always @(negedge clk) begin
    if (!rst) begin
      check(int'(row_addr) == m_row, "R7", "row_addr", row_addr, m_row);
      check(int'(com_idx) == m_com, "R6", "com_idx", com_idx, m_com);
      check(line_strobe == m_strobe, "R4", "line_strobe", line_strobe, m_strobe);
      n_chk++;
      if (seg_data !== m_seg) begin
        n_bad++;
        $display("FAIL R8 seg_data: actual %h expected %h", seg_data, m_seg);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) com_tick = 1'b1;
      @(negedge clk) com_tick = 1'b0;
    end
  endtask

  task automatic flip();
    @(negedge clk) frame_pol = ~frame_pol;
    @(negedge clk);
  endtask

  task automatic write_start(input int v);
    @(negedge clk) begin start_we = 1'b1; start_data = 8'(v); end
    @(negedge clk) start_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    idle(3);
    @(negedge clk) rst = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    // Phase A: forward scan, normal polarity.
    idle(3);
    @(negedge clk) rst = 1'b0;
    check(row_addr == 0 && com_idx == 0 && !line_strobe && seg_data == '0,
          "R1", "reset outputs", row_addr, 0);
    write_start(250);
    tick(3);
    check(row_addr == 3, "R2", "mid-frame write not adopted", row_addr, 3);
    flip();
    check(line_strobe == 1'b1, "R3", "strobe after frame flip", line_strobe, 1);
    check(row_addr == 10, "R7", "wrap of start 250", row_addr, 10);
    idle(1);
    check(seg_data == pat(10), "R8", "latched row normal", 0, 0);
    tick(87);
    check(row_addr == 97 && com_idx == 87, "R5", "last line", row_addr, 97);
    tick(3);
    check(row_addr == 97 && !line_strobe, "R5", "hold at last line", row_addr, 97);
    @(negedge clk) perturb = 1'b1;
    idle(3);
    check(seg_data == pat(97), "R9", "seg stable under RAM disturbance", 0, 0);
    @(negedge clk) begin perturb = 1'b0; inverse = 1'b1; end
    idle(2);
    check(seg_data == pat(97), "R9", "inverse alone has no effect", 0, 0);
    // Write coincident with frame flip is kept for the next frame.
    @(negedge clk) begin start_we = 1'b1; start_data = 8'd5; frame_pol = ~frame_pol; end
    @(negedge clk) start_we = 1'b0;
    check(row_addr == 10, "R2", "coincident write deferred", row_addr, 10);
    idle(1);
    check(seg_data == ~pat(10), "R8", "latched row inverse", 0, 0);
    flip();
    check(row_addr == 5, "R2", "write adopted at next frame", row_addr, 5);
    tick(2);
    // Tick and flip together: flip wins.
    @(negedge clk) begin com_tick = 1'b1; frame_pol = ~frame_pol; end
    @(negedge clk) com_tick = 1'b0;
    check(row_addr == 5 && com_idx == 0, "R4", "flip beats tick", row_addr, 5);
    idle(2);

    // Phase B: reverse scan.
    @(negedge clk) begin scan_rev = 1'b1; inverse = 1'b0; frame_pol = 1'b0; end
    do_reset();
    flip();
    check(com_idx == 87 && row_addr == 87, "R6", "reverse first line", com_idx, 87);
    write_start(40);
    flip();
    check(row_addr == 7, "R6", "reverse with start 40", row_addr, 7);
    tick(1);
    check(com_idx == 86 && row_addr == 6, "R6", "reverse step", com_idx, 86);
    tick(90);
    check(com_idx == 0 && row_addr == 40, "R5", "reverse hold", com_idx, 0);
    idle(3);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule